// File: doc/BRIEF.md
# PRBS Bit Error Checker with Self-Seeding Sync

This block is one receive lane's bit error checker. It takes recovered parallel data one word per valid cycle and compares it with an expected pattern: one of three PRBS polynomials or a fixed all-zero pattern. For PRBS patterns the checker needs no external seed. After a start pulse it loads its local pattern history from the first received word. It then free-runs the local sequence over a programmable sync window and counts mismatching bits. If that count is at or below a programmable threshold, the checker declares lock. Otherwise it discards the seed, loads a new one from the next word and tries again.

Once locked, the local sequence keeps free-running and is never reloaded from the line. The block counts bit errors and compared bits in saturating 32-bit counters. In single-shot mode it stops after a programmed number of words and raises done. In repeat mode it counts without end. Each lane gets its own instance.

The data width must be at least 31 bits, so that one word fully seeds the longest polynomial. Sample counts are given in words, which means steps of the data width (32 bits by default).

Top module: `prbs_err_checker`

## Requirements
- R1: Bit 0 of each word is the earliest bit in time. `pat_sel_i` selects the expected pattern: code 0 is PRBS7 (x^7+x^6+1), code 1 is PRBS15 (x^15+x^14+1), code 2 is PRBS31 (x^31+x^28+1), and code 3 is a fixed all-zero word.
- R2: After `start_i`, the first valid word seeds the local history. The next `sync_words_i` valid words are compared against the free-running sequence (a value of 0 acts as 1). `locked_o` rises after the last word of that window when the window's error total is at or below `sync_thr_i`.
- R3: When the window's error total exceeds `sync_thr_i`, `locked_o` stays low. The next valid word reseeds the history and a new window of the same length starts.
- R4: While locked and not done, each valid word adds to `err_cnt_o` the number of set bits in the XOR of the received word and the expected word.
- R5: While locked and not done, each valid word adds the data width (32 by default) to `bit_cnt_o`.
- R6: With `repeat_i` low, `done_o` rises in the cycle after the `meas_words_i`-th measured word (0 acts as 1). After that, both counters hold.
- R7: With `repeat_i` high, `done_o` stays low and both counters keep advancing for every valid word.
- R8: `err_cnt_o` and `bit_cnt_o` saturate at all ones and never wrap.
- R9: A cycle with `valid_i` low changes no counter, no flag and no sync progress.
- R10: A `start_i` pulse in any state clears both counters, `locked_o` and `done_o` on the next cycle and begins a new sync.
- R11: After reset, all outputs are zero and the checker waits for `start_i`.
- R12: `done_o` is only ever high while `locked_o` is high, and `locked_o` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DW | Received word, bit 0 earliest |
| valid_i | input | 1 | `data_i` holds a word this cycle |
| pat_sel_i | input | 2 | Pattern code (R1) |
| sync_thr_i | input | CW | Maximum errors in a sync window that still lock |
| sync_words_i | input | CW | Sync window length in words |
| meas_words_i | input | CW | Single-shot measurement length in words |
| start_i | input | 1 | Restart: clear and resynchronize |
| repeat_i | input | 1 | Count without end when high |
| locked_o | output | 1 | Sync achieved |
| err_cnt_o | output | CW | Saturating bit error count |
| bit_cnt_o | output | CW | Saturating compared-bit count |
| done_o | output | 1 | Single-shot measurement finished |

## Verification
All three polynomials are run as clean streams that the bench generates from its own recurrence. A wrong tap or a wrong bit order in the generator then shows up as a non-zero error count or as a missing lock. Known bit flips are placed in chosen measurement words to check that errors are counted per bit, not per word. Other flips are placed inside the sync window, below and above the threshold, to separate locking from retrying. An all-ones stream against the zero pattern on a narrow-counter instance drives both counters into saturation. Gaps with valid low and garbage on the data lines check that idle cycles change nothing.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [1:0] {
    PAT_PRBS7  = 2'd0,
    PAT_PRBS15 = 2'd1,
    PAT_PRBS31 = 2'd2,
    PAT_ZERO   = 2'd3
  } pat_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_SYNC,
    ST_MEAS,
    ST_DONE
  } pec_state_e;

  localparam int unsigned HIST_W = 31;
endpackage

// File: rtl/pec_popcnt.sv
module pec_popcnt #(
  parameter int unsigned DW = 32,
  localparam int unsigned PW = $clog2(DW + 1)
) (
  input  logic [DW-1:0] vec_i,
  output logic [PW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < DW; i++) cnt_o = cnt_o + PW'(vec_i[i]);
  end
endmodule

// File: rtl/pec_sat_acc.sv
module pec_sat_acc #(
  parameter int unsigned CW = 32,
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned SW = CW + 1;
  logic [SW-1:0] sum;

  assign sum = {1'b0, cnt_o} + SW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= sum[CW] ? '1 : sum[CW-1:0];
  end
endmodule

// File: rtl/pec_pattern.sv
module pec_pattern
  import pec_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] exp_o
);
  // hist_q[0] is the most recent bit
  logic [HIST_W-1:0] hist_q, hist_nxt, seed;
  logic [4:0]        tap_a, tap_b;

  always_comb begin
    unique case (pat_e'(sel_i))
      PAT_PRBS7:  begin tap_a = 5'd6;  tap_b = 5'd7;  end
      PAT_PRBS15: begin tap_a = 5'd14; tap_b = 5'd15; end
      default:    begin tap_a = 5'd28; tap_b = 5'd31; end
    endcase
  end

  always_comb begin
    logic nb;
    hist_nxt = hist_q;
    exp_o    = '0;
    for (int i = 0; i < DW; i++) begin
      nb       = hist_nxt[tap_a - 5'd1] ^ hist_nxt[tap_b - 5'd1];
      exp_o[i] = nb;
      hist_nxt = {hist_nxt[HIST_W-2:0], nb};
    end
    if (pat_e'(sel_i) == PAT_ZERO) exp_o = '0;
  end

  always_comb begin
    for (int k = 0; k < HIST_W; k++) seed[k] = data_i[DW-1-k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '0;
    else if (load_i) hist_q <= seed;
    else if (adv_i)  hist_q <= hist_nxt;
  end
endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
  import pec_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  input  logic [1:0]    pat_sel_i,
  input  logic [CW-1:0] sync_thr_i,
  input  logic [CW-1:0] sync_words_i,
  input  logic [CW-1:0] meas_words_i,
  input  logic          start_i,
  input  logic          repeat_i,
  output logic          locked_o,
  output logic [CW-1:0] err_cnt_o,
  output logic [CW-1:0] bit_cnt_o,
  output logic          done_o
);
  localparam int unsigned PW  = $clog2(DW + 1);
  localparam int unsigned CW1 = CW + 1;

  pec_state_e    state_q;
  logic [CW-1:0] sync_cnt_q, meas_cnt_q, sync_err;
  logic [CW-1:0] sync_len, meas_len;
  logic [DW-1:0] exp_w;
  logic [PW-1:0] pop;
  logic [CW1-1:0] sync_sum;
  logic seed_ld, sync_fire, meas_fire, win_last, meas_last;

  assign seed_ld   = !start_i && valid_i && (state_q == ST_SEED);
  assign sync_fire = !start_i && valid_i && (state_q == ST_SYNC);
  assign meas_fire = !start_i && valid_i && (state_q == ST_MEAS);

  assign sync_len  = (sync_words_i == '0) ? CW'(1) : sync_words_i;
  assign meas_len  = (meas_words_i == '0) ? CW'(1) : meas_words_i;
  assign win_last  = (sync_cnt_q >= sync_len - CW'(1));
  assign meas_last = (meas_cnt_q >= meas_len - CW'(1));
  assign sync_sum  = {1'b0, sync_err} + CW1'(pop);

  pec_pattern #(.DW(DW)) u_pattern (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (pat_sel_i),
    .load_i (seed_ld),
    .adv_i  (sync_fire || meas_fire),
    .data_i (data_i),
    .exp_o  (exp_w)
  );

  pec_popcnt #(.DW(DW)) u_popcnt (
    .vec_i (data_i ^ exp_w),
    .cnt_o (pop)
  );

  pec_sat_acc #(.CW(CW), .IW(PW)) u_sync_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i || seed_ld),
    .en_i   (sync_fire),
    .inc_i  (pop),
    .cnt_o  (sync_err)
  );

  pec_sat_acc #(.CW(CW), .IW(PW)) u_err_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (meas_fire),
    .inc_i  (pop),
    .cnt_o  (err_cnt_o)
  );

  pec_sat_acc #(.CW(CW), .IW(PW)) u_bit_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (meas_fire),
    .inc_i  (PW'(DW)),
    .cnt_o  (bit_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sync_cnt_q <= '0;
      meas_cnt_q <= '0;
    end else if (start_i) begin
      state_q    <= ST_SEED;
      sync_cnt_q <= '0;
      meas_cnt_q <= '0;
    end else if (valid_i) begin
      unique case (state_q)
        ST_SEED: begin
          state_q    <= ST_SYNC;
          sync_cnt_q <= '0;
        end
        ST_SYNC: begin
          if (win_last) begin
            sync_cnt_q <= '0;
            meas_cnt_q <= '0;
            state_q    <= (sync_sum <= {1'b0, sync_thr_i}) ? ST_MEAS : ST_SEED;
          end else begin
            sync_cnt_q <= sync_cnt_q + CW'(1);
          end
        end
        ST_MEAS: begin
          meas_cnt_q <= meas_cnt_q + CW'(1);
          if (!repeat_i && meas_last) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign locked_o = (state_q == ST_MEAS) || (state_q == ST_DONE);
  assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          start_i,
  input logic          repeat_i,
  input logic          locked_o,
  input logic          done_o,
  input logic [CW-1:0] err_cnt_o,
  input logic [CW-1:0] bit_cnt_o
);
  // R12
  done_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> locked_o);

  // R10
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!locked_o && !done_o && err_cnt_o == '0 && bit_cnt_o == '0));

  // R8
  err_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (err_cnt_o >= $past(err_cnt_o)));

  // R5
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && valid_i && locked_o && !done_o) |=>
      (bit_cnt_o == $past(bit_cnt_o) + CW'(DW) || bit_cnt_o == '1));

  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !valid_i) |=>
      ($stable(err_cnt_o) && $stable(bit_cnt_o) && $stable(locked_o) && $stable(done_o)));

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(err_cnt_o) && $stable(bit_cnt_o)));

  // R7
  repeat_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !done_o && repeat_i && !start_i) |=> !done_o);

  // R2
  lock_on_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(valid_i));
endmodule

bind prbs_err_checker pec_checker #(.DW(DW), .CW(CW)) u_pec_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .start_i   (start_i),
  .repeat_i  (repeat_i),
  .locked_o  (locked_o),
  .done_o    (done_o),
  .err_cnt_o (err_cnt_o),
  .bit_cnt_o (bit_cnt_o)
);

// File: tb/prbs_err_checker_bench.sv
module prbs_err_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data = '0;
  logic        valid = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] thr = '0, swords = 32'd4, mwords = 32'd8;
  logic        start = 1'b0, rpt = 1'b0;
  logic        locked, done, locked_s, done_s;
  logic [31:0] errs, bits;
  logic [9:0]  errs_s, bits_s;

  int checks = 0, fails = 0;
  bit strm [NBITS];
  int wi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_err_checker u_prbs_err_checker (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .pat_sel_i(sel),
    .sync_thr_i(thr), .sync_words_i(swords), .meas_words_i(mwords),
    .start_i(start), .repeat_i(rpt), .locked_o(locked), .err_cnt_o(errs),
    .bit_cnt_o(bits), .done_o(done)
  );

  prbs_err_checker #(.DW(32), .CW(10)) u_prbs_err_checker_sat (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .pat_sel_i(sel),
    .sync_thr_i(thr[9:0]), .sync_words_i(swords[9:0]), .meas_words_i(mwords[9:0]),
    .start_i(start), .repeat_i(rpt), .locked_o(locked_s), .err_cnt_o(errs_s),
    .bit_cnt_o(bits_s), .done_o(done_s)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic make_stream(input logic [1:0] s, input logic [31:0] seedv);
    int a, b;
    case (s)
      2'd0: begin a = 6;  b = 7;  end
      2'd1: begin a = 14; b = 15; end
      default: begin a = 28; b = 31; end
    endcase
    for (int n = 0; n < NBITS; n++) begin
      if (s == 2'd3) strm[n] = 1'b0;
      else if (n < b) strm[n] = seedv[n % 32];
      else strm[n] = strm[n-a] ^ strm[n-b];
    end
    wi = 0;
  endtask

  task automatic push(input logic [31:0] w);
    data  = w;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    data  = 32'hDEAD_BEEF;
  endtask

  task automatic push_pat(input logic [31:0] mask);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[i] = strm[wi*32 + i];
    wi++;
    push(w ^ mask);
  endtask

  task automatic do_start(input logic [1:0] s, input logic [31:0] t, input logic [31:0] sw,
                          input logic [31:0] mw, input logic r);
    sel = s; thr = t; swords = sw; mwords = mw; rpt = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    check("R11", "locked", {31'b0, locked}, 32'd0);
    check("R11", "done", {31'b0, done}, 32'd0);
    check("R11", "err", errs, 32'd0);
    check("R11", "bits", bits, 32'd0);
  endtask

  task automatic t_clean(input logic [1:0] s);
    make_stream(s, 32'h9E37_79B9);
    do_start(s, 0, 4, 8, 1'b0);
    for (int k = 0; k < 5; k++) push_pat('0);
    check("R1", "clean lock", {31'b0, locked}, 32'd1);
    for (int k = 0; k < 7; k++) push_pat('0);
    check("R6", "done early", {31'b0, done}, 32'd0);
    push_pat('0);
    check("R6", "done", {31'b0, done}, 32'd1);
    check("R1", "clean errors", errs, 32'd0);
    check("R5", "bits", bits, 32'd256);
    push_pat(32'hFFFF_FFFF);
    push_pat('0);
    check("R6", "frozen bits", bits, 32'd256);
    check("R6", "frozen errs", errs, 32'd0);
  endtask

  task automatic t_errors;
    make_stream(2'd2, 32'h1234_5679);
    do_start(2'd2, 0, 4, 5, 1'b0);
    for (int k = 0; k < 5; k++) push_pat('0);
    push_pat('0);
    push_pat(32'h8000_0001);
    push_pat('0);
    push_pat(32'h0000_0F00);
    push_pat('0);
    check("R4", "popcount errs", errs, 32'd6);
    check("R4", "done", {31'b0, done}, 32'd1);
  endtask

  task automatic t_retry;
    make_stream(2'd1, 32'h0BAD_F00D);
    do_start(2'd1, 0, 4, 4, 1'b0);
    push_pat('0);
    push_pat('0);
    push_pat(32'h0001_0000);
    push_pat('0);
    push_pat('0);
    check("R3", "no lock above thr", {31'b0, locked}, 32'd0);
    for (int k = 0; k < 5; k++) push_pat('0);
    check("R3", "lock after reseed", {31'b0, locked}, 32'd1);
    check("R3", "no meas errs", errs, 32'd0);
  endtask

  task automatic t_thresh;
    make_stream(2'd0, 32'h5A5A_C3C3);
    do_start(2'd0, 2, 3, 4, 1'b0);
    push_pat('0);
    push_pat(32'h0000_0010);
    push_pat(32'h0200_0000);
    push_pat('0);
    check("R2", "lock at threshold", {31'b0, locked}, 32'd1);
    check("R2", "sync errs excluded", errs, 32'd0);
  endtask

  task automatic t_gap;
    make_stream(2'd0, 32'h7777_1111);
    do_start(2'd0, 0, 2, 10, 1'b0);
    for (int k = 0; k < 3; k++) push_pat('0);
    push_pat(32'h0000_0003);
    data = 32'hFFFF_FFFF;
    repeat (5) @(negedge clk);
    check("R9", "errs idle", errs, 32'd2);
    check("R9", "bits idle", bits, 32'd32);
    push_pat('0);
    check("R9", "stream kept", errs, 32'd2);
    check("R9", "bits resumed", bits, 32'd64);
  endtask

  task automatic t_repeat;
    make_stream(2'd2, 32'hCAFE_0001);
    do_start(2'd2, 0, 2, 2, 1'b1);
    for (int k = 0; k < 3; k++) push_pat('0);
    for (int k = 0; k < 6; k++) push_pat('0);
    check("R7", "no done", {31'b0, done}, 32'd0);
    check("R7", "bits", bits, 32'd192);
    check("R12", "still locked", {31'b0, locked}, 32'd1);
  endtask

  task automatic t_restart;
    make_stream(2'd0, 32'h3141_5927);
    do_start(2'd0, 0, 1, 20, 1'b0);
    push_pat('0);
    push_pat('0);
    push_pat(32'h0000_00F0);
    do_start(2'd0, 0, 1, 20, 1'b0);
    check("R10", "locked", {31'b0, locked}, 32'd0);
    check("R10", "errs", errs, 32'd0);
    check("R10", "bits", bits, 32'd0);
  endtask

  task automatic t_zero;
    make_stream(2'd3, '0);
    do_start(2'd3, 0, 1, 3, 1'b0);
    push_pat('0);
    push_pat('0);
    push_pat(32'hFFFF_0000);
    push_pat('0);
    push_pat(32'h0000_0001);
    check("R1", "zero pattern errs", errs, 32'd17);
    check("R1", "zero pattern done", {31'b0, done}, 32'd1);
  endtask

  task automatic t_zero_len;
    make_stream(2'd1, 32'h2468_ACE1);
    do_start(2'd1, 0, 0, 0, 1'b0);
    push_pat('0);
    push_pat('0);
    check("R2", "zero window locks", {31'b0, locked}, 32'd1);
    push_pat('0);
    check("R6", "zero length done", {31'b0, done}, 32'd1);
    check("R6", "zero length bits", bits, 32'd32);
  endtask

  task automatic t_sat;
    do_start(2'd3, 0, 1, 40, 1'b0);
    push('0);
    push('0);
    for (int k = 0; k < 40; k++) push(32'hFFFF_FFFF);
    check("R8", "err saturates", {22'b0, errs_s}, 32'h3FF);
    check("R8", "bits saturate", {22'b0, bits_s}, 32'h3FF);
    check("R8", "sat done", {31'b0, done_s}, 32'd1);
    check("R4", "wide errs", errs, 32'd1280);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(2'd0);
    t_clean(2'd1);
    t_clean(2'd2);
    t_errors();
    t_retry();
    t_thresh();
    t_gap();
    t_repeat();
    t_restart();
    t_zero();
    t_zero_len();
    t_sat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule